// File: doc/BRIEF.md
# Dual-Byte Index Register Pair

This block holds one 16-bit index value made of a high byte X and a low byte Y. A single encoded step command can count either byte on its own or count the whole word. During a word count the carry or borrow passes from the low byte into the high byte. Either byte can be written from the 8-bit data bus, and the whole word can be written from the 16-bit address bus. The address bus is also the path for moving a 16-bit value from one register to another.

Read-back uses tri-state drivers. The data bus carries one byte, chosen by its output enables. The address bus carries the whole word. The control sequencer supplies one-cycle strobes, and every state change happens on the rising clock edge. When strobes overlap, reset wins over any load, and any load wins over a step command.

Top module: `xy_index_pair`

## Requirements
- R1: A synchronous `rst` clears X and Y to zero on the next edge, and it overrides every load and step strobe given in the same cycle.
- R2: `ld_x` writes `db_i` into X and `ld_y` writes `db_i` into Y. Both strobes may be active together, and then both bytes take the data bus value.
- R3: `ld_w` writes `ab_i[15:8]` into X and `ab_i[7:0]` into Y. It overrides `ld_x` and `ld_y` in the same cycle.
- R4: Step codes 1 (X up) and 2 (X down) change X by one, wrapping within 8 bits (0xFF+1=0x00, 0x00-1=0xFF). Y is unchanged.
- R5: Step codes 3 (Y up) and 4 (Y down) change Y by one, wrapping within 8 bits. X is unchanged.
- R6: Step code 5 adds one to the 16-bit word. X is incremented only when Y wraps from 0xFF to 0x00, so 0xFFFF becomes 0x0000.
- R7: Step code 6 subtracts one from the 16-bit word. X is decremented only when Y wraps from 0x00 to 0xFF, so 0x0000 becomes 0xFFFF.
- R8: While any load strobe is active, the step command is ignored for both bytes.
- R9: `db_o` shows X while `oe_x` is high. It shows Y while `oe_y` is high and `oe_x` is low. When both are high, X wins with the default `X_WINS_DB=1`.
- R10: `ab_o` shows `{X,Y}` while `oe_ab` is high. When neither bus has its enable high, that bus is high-impedance.
- R11: Step codes 0 and 7 leave both bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, highest priority |
| ld_x | input | 1 | Write X from data bus |
| ld_y | input | 1 | Write Y from data bus |
| ld_w | input | 1 | Write X:Y from address bus |
| step_op | input | 3 | Encoded count command (0 none, 1 X+, 2 X-, 3 Y+, 4 Y-, 5 word+, 6 word-, 7 none) |
| db_i | input | 8 | Data bus value for byte writes |
| ab_i | input | 16 | Address bus value for word writes |
| oe_x | input | 1 | Drive X onto data bus |
| oe_y | input | 1 | Drive Y onto data bus |
| oe_ab | input | 1 | Drive X:Y onto address bus |
| db_o | output | 8 | Tri-state data bus output |
| ab_o | output | 16 | Tri-state address bus output |

## Verification
Every bit of the internal state is visible on `ab_o` as soon as `oe_ab` is high. A wrong carry link, a wrong wrap or a misplaced priority therefore shows up in the first sample taken after the edge that caused it. The cases that matter most are the boundary values 0x00FF, 0x0100, 0xFFFF and 0x0000 under word counting, because a broken carry chain changes only X there. The other key cases are overlapping strobes, where a load must hold off a step and a reset must beat a load. The data bus byte choice is checked separately with each enable pattern.

// File: rtl/xy_index_pkg.sv
package xy_index_pkg;

   typedef enum logic [2:0] {
      STEP_NONE  = 3'd0,
      STEP_INC_X = 3'd1,
      STEP_DEC_X = 3'd2,
      STEP_INC_Y = 3'd3,
      STEP_DEC_Y = 3'd4,
      STEP_INC_W = 3'd5,
      STEP_DEC_W = 3'd6,
      STEP_RSVD  = 3'd7
   } step_op_e;

   // Per-lane control produced by the decoder
   typedef struct packed {
      logic load;       // write this lane
      logic from_word;  // source is address bus slice, else data bus
      logic count;      // count this lane
      logic down;       // count direction
   } lane_ctl_t;

   localparam int LANE_LO   = 0;
   localparam int LANE_HI   = 1;
   localparam int NUM_LANES = 2;

endpackage

// File: rtl/xy_step_decode.sv
module xy_step_decode
   import xy_index_pkg::*;
(
   input  logic      ld_x,
   input  logic      ld_y,
   input  logic      ld_w,
   input  logic [2:0] step_op,
   input  logic      lo_wrap,
   output lane_ctl_t ctl_lo,
   output lane_ctl_t ctl_hi
);

   logic any_load;
   logic step_ok;
   logic word_op;
   step_op_e op;

   assign op       = step_op_e'(step_op);
   assign any_load = ld_x | ld_y | ld_w;
   assign step_ok  = ~any_load;
   assign word_op  = (op == STEP_INC_W) || (op == STEP_DEC_W);

   always_comb begin
      ctl_lo.load      = ld_w | ld_y;
      ctl_lo.from_word = ld_w;
      ctl_lo.down      = (op == STEP_DEC_Y) || (op == STEP_DEC_W);
      ctl_lo.count     = step_ok &&
                         ((op == STEP_INC_Y) || (op == STEP_DEC_Y) || word_op);

      ctl_hi.load      = ld_w | ld_x;
      ctl_hi.from_word = ld_w;
      ctl_hi.down      = (op == STEP_DEC_X) || (op == STEP_DEC_W);
      ctl_hi.count     = step_ok &&
                         ((op == STEP_INC_X) || (op == STEP_DEC_X) ||
                          (word_op && lo_wrap));
   end

endmodule

// File: rtl/xy_byte_lane.sv
module xy_byte_lane
   import xy_index_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  lane_ctl_t         ctl,
   input  logic [BYTE_W-1:0] db_val,
   input  logic [BYTE_W-1:0] ab_val,
   output logic [BYTE_W-1:0] q,
   output logic              wrap
);

   localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

   // wrap flags the edge this lane crosses on its next count
   assign wrap = ctl.down ? (q == '0) : (q == '1);

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (ctl.load)
         q <= ctl.from_word ? ab_val : db_val;
      else if (ctl.count)
         q <= ctl.down ? (q - ONE) : (q + ONE);
   end

endmodule

// File: rtl/xy_index_pair.sv
module xy_index_pair
   import xy_index_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit X_WINS_DB = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  ld_x,
   input  logic                  ld_y,
   input  logic                  ld_w,
   input  logic [2:0]            step_op,
   input  logic [BYTE_W-1:0]     db_i,
   input  logic [2*BYTE_W-1:0]   ab_i,
   input  logic                  oe_x,
   input  logic                  oe_y,
   input  logic                  oe_ab,
   output logic [BYTE_W-1:0]     db_o,
   output logic [2*BYTE_W-1:0]   ab_o
);

   localparam int WORD_W = NUM_LANES * BYTE_W;

   if (BYTE_W < 2) begin : g_bad_width
      $error("xy_index_pair: BYTE_W must be at least 2");
   end

   lane_ctl_t         lane_ctl  [NUM_LANES];
   logic [BYTE_W-1:0] lane_q    [NUM_LANES];
   logic              lane_wrap [NUM_LANES];

   logic [BYTE_W-1:0] x_q;
   logic [BYTE_W-1:0] y_q;
   logic [WORD_W-1:0] word_q;
   logic [BYTE_W-1:0] db_sel;

   xy_step_decode u_dec (
      .ld_x    (ld_x),
      .ld_y    (ld_y),
      .ld_w    (ld_w),
      .step_op (step_op),
      .lo_wrap (lane_wrap[LANE_LO]),
      .ctl_lo  (lane_ctl[LANE_LO]),
      .ctl_hi  (lane_ctl[LANE_HI])
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      xy_byte_lane #(.BYTE_W(BYTE_W)) u_lane (
         .clk    (clk),
         .rst    (rst),
         .ctl    (lane_ctl[g]),
         .db_val (db_i),
         .ab_val (ab_i[g*BYTE_W +: BYTE_W]),
         .q      (lane_q[g]),
         .wrap   (lane_wrap[g])
      );
   end

   assign x_q    = lane_q[LANE_HI];
   assign y_q    = lane_q[LANE_LO];
   assign word_q = {x_q, y_q};

   if (X_WINS_DB) begin : g_db_x_first
      assign db_sel = oe_x ? x_q : y_q;
   end else begin : g_db_y_first
      assign db_sel = oe_y ? y_q : x_q;
   end

   assign db_o = (oe_x | oe_y) ? db_sel : 'z;
   assign ab_o = oe_ab ? word_q : 'z;

endmodule

// File: rtl/xy_index_pair_chk.sv
module xy_index_pair_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                ld_x,
   input logic                ld_y,
   input logic                ld_w,
   input logic [2:0]          step_op,
   input logic [BYTE_W-1:0]   db_i,
   input logic [2*BYTE_W-1:0] ab_i,
   input logic                oe_ab,
   input logic [2*BYTE_W-1:0] ab_o,
   input logic [BYTE_W-1:0]   x_q,
   input logic [BYTE_W-1:0]   y_q
);

   logic no_load;
   assign no_load = !(ld_x || ld_y || ld_w);

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (x_q == '0 && y_q == '0));

   assert_x_byte_load_R2: assert property (@(posedge clk) disable iff (rst)
      (ld_x && !ld_w) |=> (x_q == $past(db_i)));

   assert_word_load_R3: assert property (@(posedge clk) disable iff (rst)
      ld_w |=> ({x_q, y_q} == $past(ab_i)));

   assert_x_inc_keeps_y_R4: assert property (@(posedge clk) disable iff (rst)
      (no_load && step_op == 3'd1) |=>
         (y_q == $past(y_q) && x_q == $past(x_q) + 1'b1));

   assert_y_dec_keeps_x_R5: assert property (@(posedge clk) disable iff (rst)
      (no_load && step_op == 3'd4) |=>
         (x_q == $past(x_q) && y_q == $past(y_q) - 1'b1));

   assert_word_inc_R6: assert property (@(posedge clk) disable iff (rst)
      (no_load && step_op == 3'd5) |=> ({x_q, y_q} == $past({x_q, y_q}) + 1'b1));

   assert_word_dec_R7: assert property (@(posedge clk) disable iff (rst)
      (no_load && step_op == 3'd6) |=> ({x_q, y_q} == $past({x_q, y_q}) - 1'b1));

   assert_load_blocks_step_R8: assert property (@(posedge clk) disable iff (rst)
      (ld_y && !ld_x && !ld_w && step_op != 3'd0) |=> $stable(x_q));

   assert_ab_shows_word_R10: assert property (@(posedge clk) disable iff (rst)
      oe_ab |-> (ab_o == {x_q, y_q}));

   assert_idle_codes_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (no_load && (step_op == 3'd0 || step_op == 3'd7)) |=>
         ($stable(x_q) && $stable(y_q)));

endmodule

bind xy_index_pair xy_index_pair_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .ld_x    (ld_x),
   .ld_y    (ld_y),
   .ld_w    (ld_w),
   .step_op (step_op),
   .db_i    (db_i),
   .ab_i    (ab_i),
   .oe_ab   (oe_ab),
   .ab_o    (ab_o),
   .x_q     (x_q),
   .y_q     (y_q)
);

// File: tb/xy_index_pair_tb.sv
module xy_index_pair_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 18;

   logic        clk = 1'b0;
   logic        rst;
   logic        ld_x, ld_y, ld_w;
   logic [2:0]  step_op;
   logic [7:0]  db_i;
   logic [15:0] ab_i;
   logic        oe_x, oe_y, oe_ab;
   logic [7:0]  db_o;
   logic [15:0] ab_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xy_index_pair dut_i (
      .clk(clk), .rst(rst), .ld_x(ld_x), .ld_y(ld_y), .ld_w(ld_w),
      .step_op(step_op), .db_i(db_i), .ab_i(ab_i),
      .oe_x(oe_x), .oe_y(oe_y), .oe_ab(oe_ab),
      .db_o(db_o), .ab_o(ab_o)
   );

   // {ld_x, ld_y, ld_w, step[2:0], db[7:0], ab[15:0], expected word[15:0]}
   localparam logic [45:0] VEC [NVEC] = '{
      {3'b001, 3'd0, 8'h00, 16'h12FF, 16'h12FF},  // R3 word load
      {3'b000, 3'd5, 8'h00, 16'h0000, 16'h1300},  // R6 carry into X
      {3'b000, 3'd6, 8'h00, 16'h0000, 16'h12FF},  // R7 borrow from X
      {3'b000, 3'd3, 8'h00, 16'h0000, 16'h1200},  // R5 Y wraps, X kept
      {3'b000, 3'd4, 8'h00, 16'h0000, 16'h12FF},  // R5 Y wraps down
      {3'b100, 3'd0, 8'hFF, 16'h0000, 16'hFFFF},  // R2 X from data bus
      {3'b000, 3'd1, 8'h00, 16'h0000, 16'h00FF},  // R4 X wraps, Y kept
      {3'b000, 3'd2, 8'h00, 16'h0000, 16'hFFFF},  // R4 X wraps down
      {3'b000, 3'd5, 8'h00, 16'h0000, 16'h0000},  // R6 full word wrap
      {3'b000, 3'd6, 8'h00, 16'h0000, 16'hFFFF},  // R7 full word wrap
      {3'b010, 3'd1, 8'h34, 16'h0000, 16'hFF34},  // R8 load blocks step
      {3'b110, 3'd0, 8'h5A, 16'h0000, 16'h5A5A},  // R2 both bytes
      {3'b101, 3'd0, 8'h11, 16'hBEEF, 16'hBEEF},  // R3 overrides byte load
      {3'b000, 3'd7, 8'h00, 16'h0000, 16'hBEEF},  // R11 code 7 idle
      {3'b000, 3'd0, 8'h00, 16'h0000, 16'hBEEF},  // R11 code 0 idle
      {3'b001, 3'd6, 8'h00, 16'h0100, 16'h0100},  // R8 word load blocks step
      {3'b000, 3'd6, 8'h00, 16'h0000, 16'h00FF},  // R7 borrow at 0x0100
      {3'b000, 3'd4, 8'h00, 16'h0000, 16'h00FE}   // R5 Y down
   };

   task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ld_x = 0; ld_y = 0; ld_w = 0; step_op = 3'd0;
      db_i = '0; ab_i = '0; oe_x = 0; oe_y = 0; oe_ab = 1;
   endtask

   // inputs are set at a negedge; state settles by the following negedge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      rst = 1;
      idle_inputs();
      @(negedge clk);
      tick();
      tick();
      rst = 0;
      check16("R1 reset state", ab_o, 16'h0000);

      for (int i = 0; i < NVEC; i++) begin
         {ld_x, ld_y, ld_w, step_op, db_i, ab_i} = VEC[i][45:16];
         tick();
         idle_inputs();
         check16($sformatf("vector %0d", i), ab_o, VEC[i][15:0]);
      end

      // state 0x00FE: data bus byte selection, R9
      oe_ab = 0;
      ld_w = 1; ab_i = 16'hA55C; tick(); idle_inputs(); oe_ab = 0;
      oe_x = 1; #1; check16("R9 X on data bus", {8'h00, db_o}, 16'h00A5);
      oe_x = 0; oe_y = 1; #1; check16("R9 Y on data bus", {8'h00, db_o}, 16'h005C);
      oe_x = 1; #1; check16("R9 X wins when both", {8'h00, db_o}, 16'h00A5);
      oe_x = 0; oe_y = 0; oe_ab = 1; #1;
      check16("R10 word on address bus", ab_o, 16'hA55C);

      // R1: reset beats load and step in the same cycle
      @(negedge clk);
      rst = 1; ld_w = 1; ab_i = 16'h7777; step_op = 3'd5;
      tick();
      rst = 0; idle_inputs();
      check16("R1 reset overrides load", ab_o, 16'h0000);

      // R1 from a non-zero value with only reset
      ld_x = 1; ld_y = 1; db_i = 8'hC3; tick(); idle_inputs();
      check16("R2 both bytes after reset", ab_o, 16'hC3C3);
      rst = 1; tick(); rst = 0;
      check16("R1 reset clears word", ab_o, 16'h0000);

      // R7 boundary from zero
      step_op = 3'd6; tick(); idle_inputs();
      check16("R7 0x0000 minus one", ab_o, 16'hFFFF);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule